// File: doc/BRIEF.md
# Run-Time Loadable AND-OR Logic Plane

This block is a sum-of-products logic plane whose connection pattern lives in a small register store and can be rewritten while the chip runs. Twelve dedicated data inputs and ten feedback lines each enter the plane twice: once as the true value and once inverted. Every product-term row holds a connection mask over those columns. The row's output is the AND of the columns it connects. Fixed OR gates then combine contiguous groups of rows, one group per output. The groups hold different numbers of rows.

Beside the summed outputs, each output group has its own enable term. Two further rows are shared by every output and serve as a global clear request and a global set request. The plane itself is purely combinational from its data inputs to its outputs. Only the configuration store is clocked. The store is loaded one row per write cycle, and a reset returns it to the erased state, in which every mask bit is 0.

Top module: `sop_plane`

## Requirements
- R1: While reset is asserted, and after it until the first write, every row mask is 0. As a result `sum_o`, `oe_o`, `clr_o` and `set_o` are all 1, whatever `din` and `fb` hold.
- R2: The columns are ordered as follows. Column 2k carries signal k and column 2k+1 carries its inverse. Signals 0 to 11 are `din[0]` to `din[11]`, and signals 12 to 21 are `fb[0]` to `fb[9]`. This gives 44 columns.
- R3: A row's term is the AND of every column whose mask bit is 1. A row whose mask is all zero gives 1.
- R4: A row that connects both column 2k and column 2k+1 for any k gives 0 for every input pattern.
- R5: Rows are mapped as follows. Row 0 drives `clr_o` and row 131 drives `set_o`. Output o owns one enable row followed by its summed rows. The groups are placed in output order, starting at row 1. The summed-row counts for outputs 0 to 9 are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8, so output 0 owns rows 1–9, output 4 owns rows 49–65 and output 9 owns rows 122–130.
- R6: `sum_o[o]` is the OR of the summed rows of output o. `oe_o[o]` equals output o's enable row.
- R7: When `cfg_we` is high with `cfg_row` below 132, a rising clock edge replaces that row's mask with `cfg_mask`. The new mask shows at the outputs after that edge and not before it. All other rows are left unchanged.
- R8: When `cfg_we` is high with `cfg_row` of 132 or above, the write leaves every row unchanged.
- R9: No register lies between `din`/`fb` and the outputs. A change on the data inputs shows at the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration store clock |
| rst_n | input | 1 | Active-low asynchronous reset; erases all rows |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 8 | Row index for the write |
| cfg_mask | input | 44 | Connection mask for the addressed row, 1 = connected |
| din | input | 12 | Dedicated data inputs, signals 0–11 |
| fb | input | 10 | Feedback inputs, signals 12–21 |
| sum_o | output | 10 | OR of each output's summed rows |
| oe_o | output | 10 | Enable term of each output |
| clr_o | output | 1 | Shared clear term (row 0) |
| set_o | output | 1 | Shared set term (row 131) |

## Verification
The only internal state is the row store, so a wrong state shows up as a wrong output level. That level appears as soon as the data inputs select the faulty row, and only on the output that owns the row. The bench therefore places programmed rows at group edges: the last row of one group and the first row of the next. A write that lands one row off, or that wraps an illegal index onto a legal row, then moves a level on a neighbouring output or on an input vector that should not respond. Write timing is checked on both sides of the committing edge.

// File: rtl/sop_pkg.sv
package sop_pkg;
   // summed-row count of output o: grows by two toward the middle, symmetric
   function automatic int grp_len(int o, int n_out, int base_len);
      int d;
      d = (o < n_out - 1 - o) ? o : n_out - 1 - o;
      return base_len + 2 * d;
   endfunction

   // first row (the enable row) of output o; row 0 is the clear term
   function automatic int grp_base(int o, int n_out, int base_len);
      int b;
      b = 1;
      for (int k = 0; k < o; k++) b += 1 + grp_len(k, n_out, base_len);
      return b;
   endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
   parameter int ROWS  = 132,
   parameter int NCOL  = 44,
   parameter int ROW_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ROW_W-1:0]          row,
   input  logic [NCOL-1:0]           mask,
   output logic [ROWS-1:0][NCOL-1:0] rows_q
);
   logic in_range;
   assign in_range = (int'(row) < ROWS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows_q <= '0;
      end else if (we && in_range) begin
         rows_q[row] <= mask;
      end
   end

   // R1: reset leaves the store erased
   a_r1_erased: assert property (@(posedge clk) !rst_n |=> (rows_q == '0));
   // R7: a legal write lands in the addressed row
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(row) < ROWS) |=> (rows_q[$past(row)] == $past(mask)));
   // R8: an illegal index changes nothing
   a_r8_bad_row_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(row) >= ROWS) |=> $stable(rows_q));
endmodule

// File: rtl/sop_term.sv
module sop_term #(
   parameter int NCOL = 44
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCOL-1:0] mask,
   input  logic [NCOL-1:0] cols,
   output logic            term
);
   localparam int NPAIR = NCOL / 2;

   if (NCOL % 2 != 0) begin : g_bad_ncol
      $error("sop_term: column count must be even");
   end

   // open connection passes 1, so an empty mask yields 1
   assign term = &(cols | ~mask);

   logic [NPAIR-1:0] pair_hit;
   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      assign pair_hit[k] = mask[2*k] & mask[2*k+1];
   end

   // R3: nothing connected gives 1
   a_r3_empty_true: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> term);
   // R4: a signal and its inverse both connected give 0
   a_r4_conflict_false: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_hit) |-> !term);
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
   parameter int LEN = 8
) (
   input  logic [LEN:0] terms,
   output logic         sum,
   output logic         oe
);
   if (LEN < 1) begin : g_bad_len
      $error("sop_or_group: group needs at least one summed row");
   end

   // terms[0] is the enable row, the rest feed the OR
   assign oe  = terms[0];
   assign sum = |terms[LEN:1];
endmodule

// File: rtl/sop_plane.sv
module sop_plane
   import sop_pkg::*;
#(
   parameter  int N_IN     = 12,
   parameter  int N_FB     = 10,
   parameter  int N_OUT    = 10,
   parameter  int BASE_LEN = 8,
   localparam int NSIG     = N_IN + N_FB,
   localparam int NCOL     = 2 * NSIG,
   localparam int ROWS     = grp_base(N_OUT, N_OUT, BASE_LEN) + 1,
   localparam int ROW_W    = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [ROW_W-1:0] cfg_row,
   input  logic [NCOL-1:0]  cfg_mask,
   input  logic [N_IN-1:0]  din,
   input  logic [N_FB-1:0]  fb,
   output logic [N_OUT-1:0] sum_o,
   output logic [N_OUT-1:0] oe_o,
   output logic             clr_o,
   output logic             set_o
);
   localparam int CLR_ROW = 0;
   localparam int SET_ROW = ROWS - 1;

   if (N_OUT % 2 != 0) begin : g_bad_nout
      $error("sop_plane: output count must be even for the symmetric row split");
   end
   if (N_IN < 1 || N_FB < 1 || BASE_LEN < 1) begin : g_bad_size
      $error("sop_plane: sizes must be positive");
   end

   // column vector: true at even, inverse at odd
   logic [NSIG-1:0] sig;
   logic [NCOL-1:0] cols;
   assign sig = {fb, din};
   for (genvar k = 0; k < NSIG; k++) begin : g_col
      assign cols[2*k]   = sig[k];
      assign cols[2*k+1] = ~sig[k];
   end

   logic [ROWS-1:0][NCOL-1:0] rows_q;
   sop_cfg_store #(.ROWS(ROWS), .NCOL(NCOL), .ROW_W(ROW_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .row    (cfg_row),
      .mask   (cfg_mask),
      .rows_q (rows_q)
   );

   logic [ROWS-1:0] terms;
   for (genvar r = 0; r < ROWS; r++) begin : g_term
      sop_term #(.NCOL(NCOL)) u_term (
         .clk   (clk),
         .rst_n (rst_n),
         .mask  (rows_q[r]),
         .cols  (cols),
         .term  (terms[r])
      );
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      localparam int BASE = grp_base(o, N_OUT, BASE_LEN);
      localparam int LEN  = grp_len(o, N_OUT, BASE_LEN);
      sop_or_group #(.LEN(LEN)) u_grp (
         .terms (terms[BASE+LEN:BASE]),
         .sum   (sum_o[o]),
         .oe    (oe_o[o])
      );
   end

   assign clr_o = terms[CLR_ROW];
   assign set_o = terms[SET_ROW];
endmodule

// File: tb/test_sop_plane.sv
module test_sop_plane;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_row = '0;
   logic [43:0] cfg_mask = '0;
   logic [11:0] din = '0;
   logic [9:0]  fb = '0;
   logic [9:0]  sum_o, oe_o;
   logic        clr_o, set_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sop_plane i_sop_plane (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
      .cfg_mask(cfg_mask), .din(din), .fb(fb),
      .sum_o(sum_o), .oe_o(oe_o), .clr_o(clr_o), .set_o(set_o)
   );

   // vector: {din, fb, sum, oe, clr, set}
   localparam int NV = 6;
   localparam logic [43:0] VEC [NV] = '{
      {12'h000, 10'h000, 10'h011, 10'h010, 1'b0, 1'b0},
      {12'hFFF, 10'h3FF, 10'h201, 10'h011, 1'b1, 1'b0},
      {12'h028, 10'h001, 10'h010, 10'h010, 1'b0, 1'b1},
      {12'h818, 10'h020, 10'h001, 10'h010, 1'b0, 1'b0},
      {12'h801, 10'h200, 10'h211, 10'h011, 1'b0, 1'b0},
      {12'h03E, 10'h021, 10'h001, 10'h010, 1'b1, 1'b0}
   };

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(int row, logic [43:0] m);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 8'(row); cfg_mask = m;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic all_out(string req, logic [21:0] exp);
      #2;
      chk(req, {sum_o, oe_o, clr_o, set_o}, exp);
   endtask

   initial begin
      // R1 / R3: erased store, every term is 1
      repeat (2) @(negedge clk);
      all_out("R1 reset", {10'h3FF, 10'h3FF, 1'b1, 1'b1});
      rst_n = 1'b1;
      @(negedge clk);
      din = 12'hA5C; fb = 10'h1B3;
      all_out("R9/R3 erased any input", {10'h3FF, 10'h3FF, 1'b1, 1'b1});

      // R4: din[0] true and inverse in every row
      for (int r = 0; r < 132; r++) wr(r, 44'h3);
      din = 12'hFFF; fb = 10'h3FF;
      all_out("R4 conflict rows", 22'h0);
      din = 12'h000; fb = 10'h000;
      all_out("R4 conflict rows zero in", 22'h0);

      // R2/R5/R6 program edge rows
      wr(0,   44'h1 << 2);                          // clr = din1
      wr(131, (44'h1 << 5) | (44'h1 << 24));        // set = ~din2 & fb0
      wr(1,   44'h1 << 42);                         // oe0 = fb9
      wr(2,   (44'h1 << 6) | (44'h1 << 8));         // din3 & din4
      wr(9,   44'h1 << 11);                         // ~din5, last row of out0
      wr(49,  44'h0);                               // oe4 = 1
      wr(65,  44'h1 << 35);                         // ~fb5, last row of out4
      wr(130, (44'h1 << 22) | 44'h1);               // din11 & din0

      for (int v = 0; v < NV; v++) begin
         din = VEC[v][43:32]; fb = VEC[v][31:22];
         all_out($sformatf("R2/R3/R5/R6 vector %0d", v), VEC[v][21:0]);
      end

      // R7: row 10 is output 1's enable; new mask only after the edge
      din = VEC[2][43:32]; fb = VEC[2][31:22];
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 8'd10; cfg_mask = '0;
      #5;
      chk("R7 before edge oe", 64'(oe_o), 64'h010);
      @(negedge clk);
      cfg_we = 1'b0;
      #2;
      chk("R7 after edge oe", 64'(oe_o), 64'h012);
      chk("R7 other rows kept sum", 64'(sum_o), 64'h010);

      // R8: illegal rows; a wrap would hit row 4 or 72
      wr(132, 44'h0);
      wr(200, 44'h0);
      wr(255, 44'h0);
      all_out("R8 bad rows ignored", {10'h010, 10'h012, 1'b0, 1'b1});

      // R5 boundaries: row 66 enables out5, row 123 is out9's first sum row
      wr(66, 44'h0);
      wr(123, 44'h0);
      all_out("R5 boundary rows", {10'h210, 10'h032, 1'b0, 1'b1});

      // R9: data change without clock edge
      @(negedge clk);
      #12;
      din = VEC[1][43:32]; fb = VEC[1][31:22];
      #1;
      chk("R9 no clock needed", {54'h0, sum_o}, 64'h201);
      @(negedge clk);

      // R1: reset erases everything again
      rst_n = 1'b0;
      all_out("R1 re-reset", {10'h3FF, 10'h3FF, 1'b1, 1'b1});
      rst_n = 1'b1;
      @(negedge clk);
      all_out("R1 after release", {10'h3FF, 10'h3FF, 1'b1, 1'b1});

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule